// File: doc/BRIEF.md
# Dual Performance Counter Unit

This block counts hardware events for a processor core using two 32-bit counters. The core supplies one strobe per event source each cycle, a strobe from a dedicated "park" source, and its current privilege mode. Software reaches the block through a single read/write port that selects one of two 64-bit registers. The control register holds an event-select code for each counter, three privilege-mode count enables shared by both counters, an interrupt enable and two sticky overflow flags. The counter register carries both counters, one in each half.

The count enables are shared by both counters, so one counter cannot be stopped on its own. A counter that software does not need is instead pointed at the park code. The park source fires only on an instruction pattern that ordinary code never contains, so that counter stays effectively still while the other one runs. To sample every N events, software preloads a counter with the two's complement of N. The counter then wraps after N events, and the wrap raises a level interrupt.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset both registers read as zero and `irq_o` is low.
- R2: A counter increments by one in a cycle where its selected strobe is high and the enable for the current mode is set. The mode encodings are 0 user (control bit 4), 1 supervisor (control bit 5), 2 hypervisor (control bit 3) and 3 none (never counts).
- R3: When a counter wraps from 0xFFFFFFFF to 0, its sticky flag is set: control bit 32 for the lower counter and bit 33 for the upper counter. Increments that do not wrap leave the flag alone.
- R4: A sticky flag stays set until a control write stores a 0 into it. An overflow in the same cycle as a control write still sets the flag.
- R5: `irq_o` is high exactly while at least one sticky flag is set and control bits 1:0 are both 1.
- R6: The lower counter's event-select code sits in control bits 17:6 and the upper counter's in bits 30:19. A code below 16 selects the strobe `event_i[code]`.
- R7: Code 0x220 selects `park_i`. Every other code from 16 up counts nothing.
- R8: The lower counter sits in counter-register bits 31:0 and the upper counter in bits 63:32. A counter write loads only the halves enabled in `wr_mask_i` (bit 0 lower, bit 1 upper) and leaves the other half unchanged.
- R9: A write to a counter half takes priority over an increment of that half in the same cycle and never raises an overflow.
- R10: `rdata_o` shows the selected register (0 control, 1 counter) as it stands before the current cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| event_i | input | 16 | Per-cycle event strobes, indexed by event code |
| park_i | input | 1 | Strobe of the never-occurring instruction selected by code 0x220 |
| mode_i | input | 2 | Current privilege mode: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| reg_sel_i | input | 1 | Register select: 0 control, 1 counter |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_mask_i | input | 2 | Counter half enables for a counter write (bit 0 lower, bit 1 upper) |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Current value of the selected register |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The assertions take a few things for granted about the inputs. The mode input and the write controls are steady and free of X around each clock edge. Writes do not start until a few cycles after reset is released. No assertion depends on which event codes are programmed. The stimulus changes all inputs only on falling clock edges and waits out the reset synchronizer before its first access. It programs event codes from the strobe range, the park code and unused codes. It preloads counters just below the wrap point, so overflows, sticky flags that race a control write, and writes that collide with increments all occur often.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_HV   = 2'd2,
    MODE_NONE = 2'd3
  } pcu_mode_e;

  localparam int IRQ_LSB   = 0;
  localparam int HV_BIT    = 3;
  localparam int USR_BIT   = 4;
  localparam int SUP_BIT   = 5;
  localparam int LO_SEL_SH = 6;
  localparam int STK_LSB   = 32;
endpackage

// File: rtl/pcu_event_sel.sv
module pcu_event_sel #(
  parameter int SEL_W = 12,
  parameter int NUM_EVT = 16,
  parameter logic [SEL_W-1:0] PARK_CODE = 12'h220
) (
  input  logic [SEL_W-1:0]   code_i,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               park_i,
  output logic               hit_o
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  always_comb begin
    hit_o = 1'b0;
    if (code_i == PARK_CODE) begin
      hit_o = park_i;
    end else if (code_i < SEL_W'(NUM_EVT)) begin
      hit_o = event_i[code_i[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = wr_i | inc_i;
    cnt_d  = wr_i ? wdata_i : (cnt_q + W'(1));
    wrap_o = inc_i & ~wr_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 12,
  parameter int NUM_EVT = 16,
  parameter logic [SEL_W-1:0] PARK_CODE = 12'h220
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   event_i,
  input  logic                 park_i,
  input  logic [1:0]           mode_i,
  input  logic                 reg_sel_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_mask_i,
  input  logic [2*CNT_W-1:0]   wdata_i,
  output logic [2*CNT_W-1:0]   rdata_o,
  output logic                 irq_o
);
  import pcu_pkg::*;

  localparam int REG_W = 2 * CNT_W;
  localparam int UP_SEL_SH = LO_SEL_SH + SEL_W + 1;
  localparam int NUM_CNT = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [REG_W-1:0]                ctl_q;
  logic [REG_W-1:0]                ctl_d;
  logic                            ctl_en;
  logic                            ctl_wr;
  logic                            cnt_wr_any;
  logic                            count_en;
  logic [NUM_CNT-1:0]              wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q;

  assign ctl_wr     = wr_en_i & ~reg_sel_i;
  assign cnt_wr_any = wr_en_i & reg_sel_i;

  always_comb begin
    unique case (pcu_mode_e'(mode_i))
      MODE_USER: count_en = ctl_q[USR_BIT];
      MODE_SUP:  count_en = ctl_q[SUP_BIT];
      MODE_HV:   count_en = ctl_q[HV_BIT];
      default:   count_en = 1'b0;
    endcase
  end

  genvar h;
  generate
    for (h = 0; h < NUM_CNT; h++) begin : g_cnt
      localparam int SH = (h == 0) ? LO_SEL_SH : UP_SEL_SH;
      logic hit;
      pcu_event_sel #(
        .SEL_W(SEL_W), .NUM_EVT(NUM_EVT), .PARK_CODE(PARK_CODE)
      ) u_sel (
        .code_i (ctl_q[SH +: SEL_W]),
        .event_i(event_i),
        .park_i (park_i),
        .hit_o  (hit)
      );
      pcu_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .inc_i  (hit & count_en),
        .wr_i   (cnt_wr_any & wr_mask_i[h]),
        .wdata_i(wdata_i[h*CNT_W +: CNT_W]),
        .cnt_o  (cnt_q[h]),
        .wrap_o (wrap[h])
      );
    end
  endgenerate

  always_comb begin
    ctl_d = ctl_wr ? wdata_i : ctl_q;
    ctl_d[STK_LSB +: NUM_CNT] = ctl_d[STK_LSB +: NUM_CNT] | wrap;
    ctl_en = ctl_wr | (|wrap);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign rdata_o = reg_sel_i ? cnt_q : ctl_q;
  assign irq_o   = (|ctl_q[STK_LSB +: NUM_CNT]) & (&ctl_q[IRQ_LSB +: 2]);
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_int_n,
  input logic               irq_o,
  input logic [2*CNT_W-1:0] ctl_q,
  input logic [2*CNT_W-1:0] cnt_flat,
  input logic               wr_en_i,
  input logic               reg_sel_i,
  input logic [1:0]         wr_mask_i,
  input logic [2*CNT_W-1:0] wdata_i,
  input logic [1:0]         mode_i
);
  logic ctl_wr;
  logic cnt_wr;
  assign ctl_wr = wr_en_i & ~reg_sel_i;
  assign cnt_wr = wr_en_i & reg_sel_i;

  // R5: interrupt only with both enable bits set
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (ctl_q[1:0] == 2'b11));

  // R4: sticky flag holds without a control write
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_q[32] && !ctl_wr) |=> ctl_q[32]);

  // R3: a flag rising without a control write means the lower counter wrapped to zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(ctl_q[32]) && !$past(ctl_wr)) |-> (cnt_flat[CNT_W-1:0] == '0));

  // R9: a write to the lower half lands regardless of increments
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnt_wr && wr_mask_i[0]) |=> (cnt_flat[CNT_W-1:0] == $past(wdata_i[CNT_W-1:0])));

  // R2: mode "none" and no counter write leave both counters still
  p_idle_still_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_i == 2'd3 && !cnt_wr) |=> $stable(cnt_flat));
endmodule

bind perf_counter_unit pcu_checker #(.CNT_W(CNT_W)) u_pcu_checker (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .irq_o    (irq_o),
  .ctl_q    (ctl_q),
  .cnt_flat (cnt_q),
  .wr_en_i  (wr_en_i),
  .reg_sel_i(reg_sel_i),
  .wr_mask_i(wr_mask_i),
  .wdata_i  (wdata_i),
  .mode_i   (mode_i)
);

// File: tb/tb_perf_counter_unit.sv
`timescale 1ns/1ps
module tb_perf_counter_unit;
  logic        clk;
  logic        rst_n;
  logic [15:0] event_i;
  logic        park_i;
  logic [1:0]  mode_i;
  logic        reg_sel_i;
  logic        wr_en_i;
  logic [1:0]  wr_mask_i;
  logic [63:0] wdata_i;
  logic [63:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] m_ctl;
  logic [31:0] m_cnt [2];

  perf_counter_unit dut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .park_i(park_i),
    .mode_i(mode_i), .reg_sel_i(reg_sel_i), .wr_en_i(wr_en_i),
    .wr_mask_i(wr_mask_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] mk_ctl(input logic [1:0] ie, input logic hv,
      input logic us, input logic sv, input logic [11:0] lo, input logic [11:0] up);
    logic [63:0] v;
    v = '0;
    v[1:0] = ie; v[3] = hv; v[4] = us; v[5] = sv;
    v[17:6] = lo; v[30:19] = up;
    return v;
  endfunction

  function automatic logic sel_hit(input logic [11:0] code, input logic [15:0] ev, input logic pk);
    if (code == 12'h220) return pk;
    if (code < 12'd16) return ev[code[3:0]];
    return 1'b0;
  endfunction

  function automatic logic mode_en(input logic [63:0] c, input logic [1:0] m);
    case (m)
      2'd0: return c[4];
      2'd1: return c[5];
      2'd2: return c[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (m_ctl[32] | m_ctl[33]) & (m_ctl[1:0] == 2'b11);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    reg_sel_i = 1'b0; #1;
    chk({tag, " ctl"}, rdata_o, m_ctl);
    reg_sel_i = 1'b1; #1;
    chk({tag, " cnt"}, rdata_o, {m_cnt[1], m_cnt[0]});
    chk({tag, " irq"}, {63'd0, irq_o}, {63'd0, m_irq()});
  endtask

  // call at a falling edge; drives, checks R10 read-before-update, advances one cycle
  task automatic step(input logic [15:0] ev, input logic pk, input logic [1:0] md,
      input logic wr, input logic sel, input logic [1:0] msk, input logic [63:0] wd);
    logic [11:0] code;
    logic inc, wh;
    logic [1:0] wrapv;
    logic [63:0] nctl;
    event_i = ev; park_i = pk; mode_i = md; wr_en_i = wr;
    reg_sel_i = sel; wr_mask_i = msk; wdata_i = wd;
    #1;
    chk("R10 read-before-update", rdata_o, sel ? {m_cnt[1], m_cnt[0]} : m_ctl);
    wrapv = 2'b00;
    for (int h = 0; h < 2; h++) begin
      code = (h == 0) ? m_ctl[17:6] : m_ctl[30:19];
      inc = sel_hit(code, ev, pk) & mode_en(m_ctl, md);
      wh = wr & sel & msk[h];
      if (wh) m_cnt[h] = wd[h*32 +: 32];
      else if (inc) begin
        if (m_cnt[h] == 32'hFFFF_FFFF) wrapv[h] = 1'b1;
        m_cnt[h] = m_cnt[h] + 32'd1;
      end
    end
    nctl = (wr && !sel) ? wd : m_ctl;
    nctl[33:32] = nctl[33:32] | wrapv;
    m_ctl = nctl;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(16'h0, 1'b0, 2'd3, 1'b0, 1'b0, 2'b00, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] c;
    void'($urandom(32'd20240611));
    event_i = '0; park_i = 0; mode_i = 2'd3; reg_sel_i = 0; wr_en_i = 0;
    wr_mask_i = 0; wdata_i = '0;
    m_ctl = '0; m_cnt[0] = '0; m_cnt[1] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_regs("R1 reset");

    // R6/R2: lower selects strobe 2, upper strobe 5, user enabled
    c = mk_ctl(2'b00, 1'b0, 1'b1, 1'b0, 12'd2, 12'd5);
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    check_regs("R6 ctl program");
    step(16'h0004, 0, 2'd0, 0, 0, 2'b00, 0);
    step(16'h0024, 0, 2'd0, 0, 0, 2'b00, 0);
    step(16'h0004, 0, 2'd0, 0, 0, 2'b00, 0);
    check_regs("R6 select fields");
    if (m_cnt[0] != 32'd3 || m_cnt[1] != 32'd1) chk("R6 model", 64'd1, 64'd0);
    step(16'hFFFF, 1, 2'd3, 0, 0, 2'b00, 0);
    check_regs("R2 mode none");
    step(16'hFFFF, 1, 2'd1, 0, 0, 2'b00, 0);
    check_regs("R2 supervisor disabled");
    step(16'hFFFF, 1, 2'd2, 0, 0, 2'b00, 0);
    check_regs("R2 hypervisor disabled");
    c = mk_ctl(2'b00, 1'b1, 1'b0, 1'b1, 12'd2, 12'd5);
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    step(16'h0024, 0, 2'd2, 0, 0, 2'b00, 0);
    step(16'h0024, 0, 2'd1, 0, 0, 2'b00, 0);
    step(16'h0024, 0, 2'd0, 0, 0, 2'b00, 0);
    check_regs("R2 hv and sup modes");

    // R7: park code and unused code
    c = mk_ctl(2'b00, 1'b0, 1'b1, 1'b0, 12'h220, 12'h100);
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    step(16'hFFFF, 0, 2'd0, 0, 0, 2'b00, 0);
    step(16'hFFFF, 1, 2'd0, 0, 0, 2'b00, 0);
    step(16'h0000, 1, 2'd0, 0, 0, 2'b00, 0);
    check_regs("R7 park and unused codes");

    // R8: half writes
    step(16'h0, 0, 2'd3, 1, 1, 2'b01, 64'h1111_2222_3333_4444);
    check_regs("R8 lower-only write");
    step(16'h0, 0, 2'd3, 1, 1, 2'b10, 64'h5555_6666_7777_8888);
    check_regs("R8 upper-only write");

    // R3/R5: wrap of lower counter with interrupt enabled
    c = mk_ctl(2'b11, 1'b0, 1'b1, 1'b0, 12'd2, 12'd7);
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    step(16'h0, 0, 2'd3, 1, 1, 2'b11, 64'hFFFF_FFF0_FFFF_FFFE);
    step(16'h0004, 0, 2'd0, 0, 0, 2'b00, 0);
    check_regs("R3 no flag before wrap");
    step(16'h0004, 0, 2'd0, 0, 0, 2'b00, 0);
    check_regs("R3 lower wrap");
    chk("R5 irq after wrap", {63'd0, irq_o}, 64'd1);
    idle(3);
    check_regs("R4 sticky hold");
    c[32] = 1'b1; c[1:0] = 2'b01;
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    check_regs("R5 irq masked by 01");
    c[1:0] = 2'b11; c[32] = 1'b0;
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    check_regs("R4 clear by write");
    chk("R4 irq low after clear", {63'd0, irq_o}, 64'd0);

    // R4: overflow racing a clearing control write, upper counter
    step(16'h0, 0, 2'd3, 1, 1, 2'b10, 64'hFFFF_FFFF_0000_0000);
    step(16'h0080, 0, 2'd0, 1, 0, 2'b00, c);
    check_regs("R4 overflow beats clear");

    // R9: counter write collides with increment
    step(16'h0, 0, 2'd3, 1, 1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    c[33:32] = 2'b00;
    step(16'h0, 0, 2'd3, 1, 0, 2'b00, c);
    step(16'h0084, 0, 2'd0, 1, 1, 2'b01, 64'h0000_0000_0000_0ABC);
    check_regs("R9 write wins");

    // R2: random mix, expected values from the bench model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ev;
      logic [63:0] wd;
      logic [11:0] codes [2];
      int r;
      ev = 16'($urandom);
      r = $urandom_range(0, 15);
      for (int h = 0; h < 2; h++) begin
        case ($urandom_range(0, 3))
          0: codes[h] = 12'h220;
          1: codes[h] = 12'($urandom_range(16, 4095));
          default: codes[h] = 12'($urandom_range(0, 15));
        endcase
      end
      if (r == 0) begin
        wd = {$urandom, $urandom};
        wd[17:6] = codes[0]; wd[30:19] = codes[1];
        step(ev, 1'($urandom), 2'($urandom), 1, 0, 2'b00, wd);
      end else if (r == 1) begin
        wd = {32'hFFFF_FFF0 | 32'($urandom_range(0, 15)),
              32'hFFFF_FFF0 | 32'($urandom_range(0, 15))};
        step(ev, 1'($urandom), 2'($urandom), 1, 1, 2'($urandom), wd);
      end else begin
        step(ev, 1'($urandom), 2'($urandom), 0, 1'($urandom), 2'b00, 64'h0);
      end
      check_regs("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule